// File: doc/BRIEF.md
# Configuration transaction controller

This block runs small configuration transactions on behalf of software through three word registers on a register bus. Software first places an operand in the data register at offset 0xA0. It then writes a control word at 0xA4 with the start bit set. In that same clock edge the block decodes the word. It then does one of three things: reads or updates an entry of the oscillator table (six motherboard entries plus a parameterised number of daughterboard entries), reads a fixed or parameterised voltage value, or raises a shutdown or reboot request. The outcome is recorded in the status register at 0xA8. Bit 0 of that register means complete and bit 1 means error.

A read transaction that succeeds puts its result in the data register, where software collects it afterwards. The control word keeps its fields for readback, but the start bit and bits 19:18 are dropped. The register set is present only when the board identity parameter is 0x190. On any other identity the three registers read as zero and writes have no effect.

Top module: `cfg_txn_ctrl`

## Requirements
- R1: After reset the data, control and status registers read 0 and both request outputs are low.
- R2: A write to the control register stores the word with bit 31 (start) and bits 19:18 cleared. The stored word reads back from 0xA4, so a start bit is never seen there.
- R3: A control write with bit 31 set loads status with 1 if the transaction is supported and with 3 if it is not. A transaction can only be supported when the controller select field (bits 29:26) is 0, the position field (bits 15:12) is 0, and the site field (bits 17:16) is 0 (motherboard) or 1 (daughterboard). The function is in bits 25:20, the device in bits 11:0, and bit 30 selects write (1) or read (0).
- R4: Function 1 with bit 30 set copies the data register into the oscillator entry chosen by site and device: motherboard devices 0 to 5, daughterboard devices below DB_OSC_N. Function 1 with bit 30 clear copies that entry into the data register.
- R5: After reset the motherboard oscillator entries hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000 for devices 0 to 5. Daughterboard entry i holds word i of DB_OSC_INIT.
- R6: A function 2 read returns 3300000 for motherboard device 0, and word i of DB_VOLT_VAL for daughterboard device i below DB_VOLT_N. A function 2 write is unsupported.
- R7: A read transaction that is unsupported leaves the data register unchanged.
- R8: A write transaction to motherboard device 0 succeeds for functions 7, 8, 9 and 11. Function 8 pulses shutdown_req and function 9 pulses reboot_req, each high for exactly the one cycle after the write edge. Every other function, device or direction combination sets the error bit and raises no request.
- R9: A write to the status register stores only bits 1:0 of the written word.
- R10: With BOARD_ID other than 0x190, all three registers read 0, writes are ignored, and no request is ever raised.
- R11: A control write with bit 31 clear starts nothing: status and the data register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 12 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
Two effects of the same launching edge land together: the status register turns complete, and a shutdown or reboot request pulse is raised (or, for a read, the data register is overwritten). The bench provokes this with function 8 and 9 writes, both directed and drawn at random, and samples status, data and both pulses in the cycle right after the write edge. It then checks in the following cycle that the pulse has dropped while status holds. A second instance with a different board identity shares the bus, so every random write also confirms that this instance stays silent.

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl #(
  parameter logic [11:0] BOARD_ID = 12'h190,
  parameter int DB_OSC_N  = 2,
  parameter int DB_VOLT_N = 2,
  parameter logic [DB_OSC_N*32-1:0]  DB_OSC_INIT = {32'd66_000_000, 32'd45_000_000},
  parameter logic [DB_VOLT_N*32-1:0] DB_VOLT_VAL = {32'd1_000_000, 32'd900_000}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        shutdown_req,
  output logic        reboot_req
);
  localparam int          MB_OSC_N  = 6;
  localparam logic [11:0] A_DATA    = 12'hA0;
  localparam logic [11:0] A_CTRL    = 12'hA4;
  localparam logic [11:0] A_STAT    = 12'hA8;
  localparam logic [31:0] CTRL_KEEP = 32'h7FF3_FFFF;
  localparam logic [31:0] MB_VOLT   = 32'd3_300_000;
  localparam bit          PRESENT   = (BOARD_ID == 12'h190);

  logic [31:0] data_q, ctrl_q;
  logic [1:0]  stat_q;
  logic [31:0] mb_osc [MB_OSC_N];
  logic [31:0] db_osc [DB_OSC_N];

  wire        is_wr = bus_wdata[30];
  wire [3:0]  dcc   = bus_wdata[29:26];
  wire [5:0]  fn    = bus_wdata[25:20];
  wire [1:0]  site  = bus_wdata[17:16];
  wire [3:0]  pos   = bus_wdata[15:12];
  wire [11:0] dev   = bus_wdata[11:0];

  wire go      = PRESENT && bus_wr && bus_addr == A_CTRL && bus_wdata[31];
  wire base_ok = dcc == 4'd0 && pos == 4'd0 && site < 2'd2;
  wire on_mb   = site == 2'd0;
  wire on_db   = site == 2'd1;
  wire osc_mb  = fn == 6'd1 && on_mb && dev < 12'(MB_OSC_N);
  wire osc_db  = fn == 6'd1 && on_db && dev < 12'(DB_OSC_N);
  wire volt_mb = fn == 6'd2 && on_mb && dev == 12'd0;
  wire volt_db = fn == 6'd2 && on_db && dev < 12'(DB_VOLT_N);
  wire ctl_fn  = fn == 6'd7 || fn == 6'd8 || fn == 6'd9 || fn == 6'd11;
  wire ctl_hit = is_wr && on_mb && dev == 12'd0 && ctl_fn;
  wire ok      = base_ok && (osc_mb || osc_db || (!is_wr && (volt_mb || volt_db)) || ctl_hit);

  logic [31:0] rd_val;
  always_comb begin
    rd_val = 32'd0;
    for (int i = 0; i < MB_OSC_N; i++)
      if (osc_mb && dev == 12'(i)) rd_val = mb_osc[i];
    for (int i = 0; i < DB_OSC_N; i++)
      if (osc_db && dev == 12'(i)) rd_val = db_osc[i];
    for (int i = 0; i < DB_VOLT_N; i++)
      if (volt_db && dev == 12'(i)) rd_val = DB_VOLT_VAL[i*32 +: 32];
    if (volt_mb) rd_val = MB_VOLT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q       <= '0;
      ctrl_q       <= '0;
      stat_q       <= '0;
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
      for (int i = 0; i < MB_OSC_N; i++)
        mb_osc[i] <= (i == 0) ? 32'd50_000_000 : (i == 1) ? 32'd23_750_000 : 32'd24_000_000;
      for (int i = 0; i < DB_OSC_N; i++)
        db_osc[i] <= DB_OSC_INIT[i*32 +: 32];
    end else begin
      shutdown_req <= go && ok && is_wr && fn == 6'd8;
      reboot_req   <= go && ok && is_wr && fn == 6'd9;
      if (PRESENT && bus_wr) begin
        case (bus_addr)
          A_DATA: data_q <= bus_wdata;
          A_CTRL: begin
            ctrl_q <= bus_wdata & CTRL_KEEP;
            if (bus_wdata[31]) begin
              stat_q <= {!ok, 1'b1};
              if (ok && !is_wr) data_q <= rd_val;
            end
          end
          A_STAT: stat_q <= bus_wdata[1:0];
          default: ;
        endcase
      end
      for (int i = 0; i < MB_OSC_N; i++)
        if (go && ok && is_wr && osc_mb && dev == 12'(i)) mb_osc[i] <= data_q;
      for (int i = 0; i < DB_OSC_N; i++)
        if (go && ok && is_wr && osc_db && dev == 12'(i)) db_osc[i] <= data_q;
    end
  end

  always_comb begin
    bus_rdata = 32'd0;
    if (PRESENT)
      case (bus_addr)
        A_DATA:  bus_rdata = data_q;
        A_CTRL:  bus_rdata = ctrl_q;
        A_STAT:  bus_rdata = {30'd0, stat_q};
        default: bus_rdata = 32'd0;
      endcase
  end

  a_r8_no_double_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reboot_req));
  a_r8_shutdown_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);
  a_r8_reboot_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reboot_req) |-> $past(bus_wr && bus_addr == A_CTRL && bus_wdata[31]));
  a_r3_start_completes: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> stat_q[0]);
  a_r9_status_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (PRESENT && bus_wr && bus_addr == A_STAT) |=> stat_q == $past(bus_wdata[1:0]));
  a_r11_no_start_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && !bus_wdata[31]) |=> $stable(stat_q));
  a_r10_absent_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !PRESENT |-> (bus_rdata == 32'd0 && !shutdown_req && !reboot_req));
endmodule

// File: tb/test_cfg_txn_ctrl.sv
module test_cfg_txn_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = 12'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] rdata, rdata_o;
  logic sd, rb, sd_o, rb_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cfg_txn_ctrl i_cfg_txn_ctrl (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata(rdata), .shutdown_req(sd), .reboot_req(rb));
  cfg_txn_ctrl #(.BOARD_ID(12'h182)) i_cfg_txn_ctrl_other (.clk, .rst_n, .bus_wr,
    .bus_addr, .bus_wdata, .bus_rdata(rdata_o), .shutdown_req(sd_o), .reboot_req(rb_o));

  logic [31:0] m_mb [6];
  logic [31:0] m_db [2];
  logic [31:0] m_data, m_ctrl;
  logic [1:0]  m_stat;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic [31:0] d_o);
    bus_addr = a; #1; d = rdata; d_o = rdata_o;
  endtask

  function automatic logic [31:0] cw(bit go, bit w, int dcc, int fn, int site, int pos, int dev);
    return {go, w, 4'(dcc), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
  endfunction

  // reference model from the requirements; returns 1 when supported
  function automatic bit model_tx(logic [31:0] w, output logic [31:0] val);
    bit base = w[29:26] == 0 && w[15:12] == 0 && w[17:16] < 2;
    int fn = int'(w[25:20]), dev = int'(w[11:0]);
    bit mb = w[17:16] == 0;
    val = 32'd0;
    if (!base) return 1'b0;
    if (fn == 1 && mb && dev < 6) begin val = m_mb[dev]; return 1'b1; end
    if (fn == 1 && !mb && dev < 2) begin val = m_db[dev]; return 1'b1; end
    if (!w[30] && fn == 2 && mb && dev == 0) begin val = 32'd3_300_000; return 1'b1; end
    if (!w[30] && fn == 2 && !mb && dev < 2) begin
      val = (dev == 0) ? 32'd900_000 : 32'd1_000_000; return 1'b1;
    end
    if (w[30] && mb && dev == 0 && (fn == 7 || fn == 8 || fn == 9 || fn == 11)) return 1'b1;
    return 1'b0;
  endfunction

  // launches a transaction and checks status, data, control readback and pulses
  task automatic txn(logic [31:0] w, string tag);
    logic [31:0] v, d, d_o;
    bit ok, exp_sd, exp_rb;
    ok = model_tx(w, v);
    exp_sd = ok && w[31] && w[30] && w[25:20] == 8;
    exp_rb = ok && w[31] && w[30] && w[25:20] == 9;
    wr(12'hA4, w);
    chk({tag, " R8 shutdown pulse"}, 32'(sd), 32'(exp_sd));
    chk({tag, " R8 reboot pulse"}, 32'(rb), 32'(exp_rb));
    chk({tag, " R10 other board quiet"}, 32'({sd_o, rb_o}), 32'd0);
    if (w[31]) begin
      if (ok && w[30] && w[25:20] == 1) begin
        if (w[17:16] == 0) m_mb[w[2:0]] = m_data; else m_db[w[0]] = m_data;
      end
      if (ok && !w[30]) m_data = v;
      m_stat = {!ok, 1'b1};
    end
    m_ctrl = w & 32'h7FF3_FFFF;
    rd(12'hA8, d, d_o);
    chk({tag, " R3 status"}, d, {30'd0, m_stat});
    rd(12'hA0, d, d_o);
    chk({tag, " R4 R7 data"}, d, m_data);
    chk({tag, " R10 other data zero"}, d_o, 32'd0);
    rd(12'hA4, d, d_o);
    chk({tag, " R2 control readback"}, d, m_ctrl);
    @(negedge clk);
    chk({tag, " R8 pulse drops"}, 32'({sd, rb}), 32'd0);
    rd(12'hA8, d, d_o);
    chk({tag, " R3 status holds"}, d, {30'd0, m_stat});
  endtask

  task automatic put_data(logic [31:0] v);
    wr(12'hA0, v);
    m_data = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    logic [31:0] d, d_o;
    int seed;
    m_mb = '{32'd50_000_000, 32'd23_750_000, 32'd24_000_000, 32'd24_000_000,
             32'd24_000_000, 32'd24_000_000};
    m_db = '{32'd45_000_000, 32'd66_000_000};
    m_data = 0; m_ctrl = 0; m_stat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'hA0, d, d_o); chk("R1 data reset", d, 0);
    rd(12'hA4, d, d_o); chk("R1 ctrl reset", d, 0);
    rd(12'hA8, d, d_o); chk("R1 stat reset", d, 0);
    chk("R1 requests low", 32'({sd, rb}), 0);

    for (int i = 0; i < 6; i++) txn(cw(1, 0, 0, 1, 0, 0, i), "R5 mb osc");
    for (int i = 0; i < 2; i++) txn(cw(1, 0, 0, 1, 1, 0, i), "R5 db osc");
    txn(cw(1, 0, 0, 2, 0, 0, 0), "R6 mb volt");
    txn(cw(1, 0, 0, 2, 1, 0, 1), "R6 db volt");
    txn(cw(1, 1, 0, 2, 0, 0, 0), "R6 volt write");
    put_data(32'h1234_5678);
    txn(cw(1, 1, 0, 1, 0, 0, 5), "R4 mb osc write");
    put_data(32'hCAFE_0001);
    txn(cw(1, 1, 0, 1, 1, 0, 1), "R4 db osc write");
    txn(cw(1, 0, 0, 1, 0, 0, 5), "R4 mb osc read");
    txn(cw(1, 0, 0, 1, 1, 0, 2), "R7 bad db device");
    txn(cw(1, 0, 1, 1, 0, 0, 0), "R3 R7 bad select");
    txn(cw(1, 0, 0, 1, 2, 0, 0), "R3 bad site");
    txn(cw(1, 0, 0, 1, 0, 1, 0), "R3 bad position");
    txn(cw(1, 1, 0, 8, 0, 0, 0), "R8 shutdown");
    txn(cw(1, 1, 0, 9, 0, 0, 0), "R8 reboot");
    txn(cw(1, 1, 0, 7, 0, 0, 0), "R8 mux no effect");
    txn(cw(1, 1, 0, 11, 0, 0, 0), "R8 mode no effect");
    txn(cw(1, 1, 0, 9, 0, 0, 1), "R8 reboot bad device");
    txn(cw(1, 0, 0, 8, 0, 0, 0), "R8 shutdown as read");
    txn(cw(1, 1, 0, 9, 1, 0, 0), "R8 reboot on db");
    txn(cw(0, 1, 0, 9, 0, 0, 0) | 32'h000C_0000, "R11 R2 no start");
    wr(12'hA8, 32'hFFFF_FFFE); m_stat = 2'b10;
    rd(12'hA8, d, d_o); chk("R9 status low bits", d, 2);
    chk("R10 other status zero", d_o, 0);
    txn(cw(0, 0, 0, 1, 0, 0, 0), "R11 read without start");

    seed = 7;
    void'($urandom(seed));
    for (int n = 0; n < 300; n++) begin
      int fns[8] = '{1, 2, 7, 8, 9, 11, 3, 0};
      logic [31:0] w;
      if ($urandom_range(3) == 0) put_data($urandom);
      w = cw($urandom_range(7) != 0, $urandom_range(1),
             ($urandom_range(7) == 0) ? 1 : 0, fns[$urandom_range(7)],
             $urandom_range(3), ($urandom_range(7) == 0) ? 2 : 0,
             $urandom_range(7));
      w[19:18] = 2'($urandom_range(3));
      txn(w, "random");
    end
    summary();
  end
endmodule